// File: doc/BRIEF.md
# Dual-Read Single-Write Register File

This block stores the general-purpose registers of a small processor core. A 4-bit register number selects one entry on each of its three ports. Two read ports and one write port can all be used in the same cycle.

Each read port is a pure combinational selection. Its output follows its register number and the stored contents with no clock involved. The write port loads its data word into the selected entry on the rising clock edge only. The highest register number, all ones (4'hF), means "no register". A read with that number returns zero, and a write with that number changes nothing. There is no forwarding from the write port to the read ports. A read of the entry being written in the same cycle therefore shows the old contents until the edge. An asynchronous active-low reset clears every entry.

Top module: `regfile_2r1w`

## Requirements
- R1: While rst_n is low, and after it is released, every entry reads as zero until it is written.
- R2: val_a_o equals the contents of the entry numbered src_a_i (0 to 14) within the same cycle, without waiting for a clock edge.
- R3: val_b_o equals the contents of the entry numbered src_b_i (0 to 14) within the same cycle, independently of port A. Both ports may name the same entry.
- R4: When dst_w_i is 0 to 14, the entry it names holds val_w_i from the rising clock edge onward.
- R5: When dst_w_i is 4'hF, no entry changes at the clock edge.
- R6: A read port whose register number is 4'hF outputs zero.
- R7: A read of the entry that is being written in the same cycle returns the old contents before the edge and the new contents after it.
- R8: A write changes only the entry named by dst_w_i. Every other entry keeps its contents.
- R9: Two reads and one write to unrelated entries in one cycle all complete correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all entries |
| src_a_i | input | 4 | Register number for read port A (4'hF = none) |
| val_a_o | output | 32 | Read data of port A |
| src_b_i | input | 4 | Register number for read port B (4'hF = none) |
| val_b_o | output | 32 | Read data of port B |
| dst_w_i | input | 4 | Register number for the write port (4'hF = none) |
| val_w_i | input | 32 | Write data |

## Verification
Read results are due in the same cycle as their register numbers, so the bench drives new numbers at the falling edge and samples both read outputs 1 ns later, still before the next rising edge. At that point the results must reflect only writes from earlier edges. A write becomes visible one rising edge after it is presented. The bench's shadow array is updated only after that edge, which means the pre-edge sample of a clashing read must show the old value. Reset effects are asynchronous and are sampled while rst_n is still low.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int RF_ID_W   = 4;
  localparam int RF_DATA_W = 32;
endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode #(
  parameter int ID_W   = 4,
  parameter int NREGS  = (1 << ID_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  dst_id,
  output logic [NREGS-1:0] wr_en
);
  localparam logic [ID_W-1:0] NONE_ID = '1;

  always_comb begin
    wr_en = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (dst_id == ID_W'(i)) wr_en[i] = 1'b1;
    end
  end

  // R8: at most one entry is enabled per cycle
  p_single_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  // R5: the none code enables nothing
  p_none_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_id == NONE_ID) |-> (wr_en == '0));
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 15
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NREGS-1:0]              wr_en,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [NREGS-1:0][DATA_W-1:0]  q
);
  logic [NREGS-1:0][DATA_W-1:0] q_nxt;

  for (genvar g = 0; g < NREGS; g++) begin : g_entry
    always_comb begin
      q_nxt[g] = q[g];
      if (wr_en[g]) q_nxt[g] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q[g] <= '0;
      else if (wr_en[g]) q[g] <= q_nxt[g];
    end

    // R4: an enabled entry takes the write data at the edge
    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[g] |=> (q[g] == $past(wr_data)));

    // R8: an entry that is not enabled holds its contents
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[g] |=> $stable(q[g]));
  end
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  parameter int NREGS  = (1 << ID_W) - 1
) (
  input  logic [ID_W-1:0]               rd_id,
  input  logic [NREGS-1:0][DATA_W-1:0]  regs,
  output logic [DATA_W-1:0]             rd_data
);
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (rd_id == ID_W'(i)) rd_data = regs[i];
    end
  end
endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w
  import regfile_pkg::*;
#(
  parameter int ID_W   = RF_ID_W,
  parameter int DATA_W = RF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   src_a_i,
  output logic [DATA_W-1:0] val_a_o,
  input  logic [ID_W-1:0]   src_b_i,
  output logic [DATA_W-1:0] val_b_o,
  input  logic [ID_W-1:0]   dst_w_i,
  input  logic [DATA_W-1:0] val_w_i
);
  localparam int              NREGS   = (1 << ID_W) - 1;
  localparam int              NPORTS  = 2;
  localparam logic [ID_W-1:0] NONE_ID = '1;

  logic [NREGS-1:0]             wr_en;
  logic [NREGS-1:0][DATA_W-1:0] bank_q;
  logic [NPORTS-1:0][ID_W-1:0]  rd_ids;
  logic [NPORTS-1:0][DATA_W-1:0] rd_vals;

  rf_write_decode #(.ID_W(ID_W), .NREGS(NREGS)) u_wdec (
    .clk    (clk),
    .rst_n  (rst_n),
    .dst_id (dst_w_i),
    .wr_en  (wr_en)
  );

  rf_storage #(.DATA_W(DATA_W), .NREGS(NREGS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (val_w_i),
    .q       (bank_q)
  );

  assign rd_ids[0] = src_a_i;
  assign rd_ids[1] = src_b_i;

  for (genvar p = 0; p < NPORTS; p++) begin : g_rport
    rf_read_mux #(.ID_W(ID_W), .DATA_W(DATA_W), .NREGS(NREGS)) u_rmux (
      .rd_id   (rd_ids[p]),
      .regs    (bank_q),
      .rd_data (rd_vals[p])
    );
  end

  assign val_a_o = rd_vals[0];
  assign val_b_o = rd_vals[1];

  // R5: a write with the none code leaves the whole bank untouched
  p_none_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_w_i == NONE_ID) |=> $stable(bank_q));

  // R6: port A with the none code reads zero
  p_none_read_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a_i == NONE_ID) |-> (val_a_o == '0));

  // R6: port B with the none code reads zero
  p_none_read_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_b_i == NONE_ID) |-> (val_b_o == '0));

  // R3: two ports naming the same entry agree
  p_ports_agree_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a_i == src_b_i) |-> (val_a_o == val_b_o));
endmodule

// File: tb/regfile_2r1w_tb.sv
module regfile_2r1w_tb;
  localparam int ID_W = 4;
  localparam int DW   = 32;
  localparam int NR   = 15;

  logic          clk;
  logic          rst_n;
  logic [ID_W-1:0] src_a, src_b, dst_w;
  logic [DW-1:0]   val_a, val_b, val_w;

  logic [DW-1:0] shadow [NR];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  regfile_2r1w u_dut (
    .clk(clk), .rst_n(rst_n),
    .src_a_i(src_a), .val_a_o(val_a),
    .src_b_i(src_b), .val_b_o(val_b),
    .dst_w_i(dst_w), .val_w_i(val_w)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [DW-1:0] expect_rd(input logic [ID_W-1:0] id);
    if (id == 4'hF) return '0;
    return shadow[id];
  endfunction

  task automatic check(input string req, input logic [DW-1:0] got,
                       input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // drive at falling edge, sample reads before the rising edge, then commit
  task automatic cycle(input logic [ID_W-1:0] a, input logic [ID_W-1:0] b,
                       input logic [ID_W-1:0] w, input logic [DW-1:0] d,
                       input string req);
    @(negedge clk);
    src_a = a; src_b = b; dst_w = w; val_w = d;
    #1;
    check({req, " port A"}, val_a, expect_rd(a));
    check({req, " port B"}, val_b, expect_rd(b));
    @(posedge clk);
    if (w != 4'hF) shadow[w] = d;
  endtask

  task automatic clear_shadow();
    for (int i = 0; i < NR; i++) shadow[i] = '0;
  endtask

  task automatic scan_all(input string req);
    for (int i = 0; i < 16; i++) cycle(ID_W'(i), ID_W'(15 - i), 4'hF, '0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    src_a = '0; src_b = '0; dst_w = 4'hF; val_w = '0;
    clear_shadow();
    repeat (2) @(negedge clk);
    // R1: reads during reset are zero
    for (int i = 0; i < 16; i++) begin
      src_a = ID_W'(i); src_b = ID_W'(i); #1;
      check("R1 in reset", val_a, '0);
      check("R1 in reset", val_b, '0);
    end
    @(negedge clk); rst_n = 1'b1;
    scan_all("R1 after release");

    // R4/R2: fill every entry, read back on both ports
    for (int i = 0; i < NR; i++) cycle(4'hF, 4'hF, ID_W'(i), 32'hA000_0000 + DW'(i * 17), "R4 fill");
    scan_all("R2 R3 readback");

    // R7: read same entry as write: old then new
    cycle(4'd3, 4'd3, 4'd3, 32'hDEAD_BEEF, "R7 before edge");
    cycle(4'd3, 4'd3, 4'hF, '0, "R7 after edge");

    // R5: none-code writes change nothing
    for (int i = 0; i < 4; i++) cycle(4'hF, 4'hF, 4'hF, 32'hFFFF_FFFF, "R5 none write");
    scan_all("R5 bank intact");

    // R6: none-code reads while a write hits entry 14
    cycle(4'hF, 4'hF, 4'd14, 32'h1234_5678, "R6 none read");
    cycle(4'd14, 4'hF, 4'hF, '0, "R6 R4 entry 14");

    // R9/R8: random mix of reads and writes
    for (int n = 0; n < 3000; n++) begin
      logic [ID_W-1:0] a, b, w;
      a = ID_W'($urandom_range(0, 15));
      b = ID_W'($urandom_range(0, 15));
      w = ($urandom_range(0, 7) == 0) ? 4'hF : ID_W'($urandom_range(0, 14));
      cycle(a, b, w, $urandom(), "R9 R8 random");
    end
    scan_all("R8 final contents");

    // R1: reset in mid-run clears everything
    @(negedge clk); rst_n = 1'b0; #1;
    clear_shadow();
    for (int i = 0; i < 16; i++) begin
      src_a = ID_W'(i); src_b = ID_W'(15 - i); #1;
      check("R1 mid-run reset", val_a, '0);
      check("R1 mid-run reset", val_b, '0);
    end
    @(negedge clk); rst_n = 1'b1;
    scan_all("R1 after second release");

    finish_run();
  end
endmodule